// File: doc/BRIEF.md
# Serial Audio Output Transmitter

This block is a master-mode stereo audio serializer. It takes a pair of parallel samples, left and right, from a source through a valid/ready handshake. It generates its own bit clock and word-select line from a faster system clock and shifts both samples out on one serial data line. Each sample carries 18 significant bits inside a 32-bit slot. A frame is 64 bit-clock periods long and always starts with the left channel.

A control input picks one of two framings. In the standard I2S framing, word select changes one bit period before the sample MSB. In the left-justified framing, word select changes in the same bit period as the MSB.

The three serial outputs stay high-impedance after reset. They start driving only when the enable input is found high at a frame boundary. They also release only at a frame boundary, so a receiver never sees a partial frame. If the source has no pair ready when a frame starts, that frame carries silence and a one-cycle underrun pulse is raised.

Top module: `serial_audio_tx`

## Requirements
- R1: While `rst_n` is low, and after reset until the first frame boundary at which `enable` is high, `sck`, `ws` and `sdo` are all high-impedance (`z`).
- R2: The outputs switch between driven and high-impedance only at a frame boundary. A release happens right after bit 63 of a frame, and driving always resumes at bit 0 of a frame.
- R3: `sck` has a period of `CLK_DIV` system clocks and is high for `CLK_DIV/2` of them. It falls at the start of each bit period. `ws` and `sdo` change only together with a falling edge of `sck`.
- R4: A frame is 64 bit periods long. Bits 0..31 carry the left sample and bits 32..63 carry the right sample, MSB first. Slot position p (0..31) carries sample bit 17-p for p < 18, and zero for p of 18 or more.
- R5: With `fmt_msb` = 1 (left-justified), `ws` is 0 during bits 0..31 and 1 during bits 32..63.
- R6: With `fmt_msb` = 0 (I2S), `ws` is 1 during bits 31..62 and 0 during bit 63 and bits 0..30.
- R7: `fmt_msb` is sampled only at a frame boundary and holds for the whole following frame.
- R8: `s_ready` is high for exactly one system clock per frame, the last clock of bit 63, and only when `enable` is high. A pair is accepted when `s_valid` and `s_ready` are both high, and it is sent in the frame that follows.
- R9: If `s_ready` is high while `s_valid` is low, the next frame sends all-zero data. `underrun` is then high for exactly one system clock, the clock right after that boundary. At all other times `underrun` is low.
- R10: Reset is synchronous and active low. It clears the handshake and `underrun` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_DIV` times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Requests driving the serial outputs; applied at frame boundaries |
| fmt_msb | input | 1 | 1 = left-justified framing, 0 = I2S framing; applied at frame boundaries |
| s_valid | input | 1 | Source holds a sample pair |
| s_ready | output | 1 | Pair accepted this clock when `s_valid` is high |
| s_left | input | SAMPLE_W | Left sample, two's complement |
| s_right | input | SAMPLE_W | Right sample, two's complement |
| underrun | output | 1 | One-clock pulse when a frame started with no pair available |
| sck | output | 1 | Bit clock, tri-stated while disabled |
| ws | output | 1 | Word select, tri-stated while disabled |
| sdo | output | 1 | Serial data, tri-stated while disabled |

## Verification
A wrong divider or bit counter shows up within one bit period: the high or low run of `sck` has the wrong length, or a `ws`/`sdo` change lands off a falling edge. A bit counter that is out of step moves the `ws` edge or a data bit to the wrong slot position. A receiver-side decode notices this in the same frame. A wrong drive or format register is caught at the first boundary after `enable` or `fmt_msb` changes, by a tri-state change away from bit 0 or by a `ws` edge one bit off. A wrong sample register is caught within 32 bits, by a single-bit pattern or an underrun frame that is not silent.

// File: rtl/sat_pkg.sv
// Shared types for the serial audio transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package sat_pkg;
    // Framing selector; the encoding matches the fmt_msb port.
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_MSB = 1'b1
    } frame_fmt_e;
endpackage

// File: rtl/sat_bitclk.sv
// Bit-clock divider. It counts system clocks within one bit period and
// produces a registered 50% duty bit clock. bit_end marks the last system
// clock of each bit period.
// Assumes: CLK_DIV is even and at least 2.
module sat_bitclk #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic bit_end,
    output logic sck_o
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] HALF_C = CW'(CLK_DIV / 2);

    logic [CW-1:0] div_cnt;
    logic [CW-1:0] div_nxt;

    // Next phase within the bit period.
    always_comb div_nxt = (div_cnt == LAST_C) ? '0 : div_cnt + 1'b1;

    // Phase counter and bit-clock level: low in the first half, high in the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sck_o   <= 1'b0;
        end else begin
            div_cnt <= div_nxt;
            sck_o   <= (div_nxt >= HALF_C);
        end
    end

    assign bit_end = (div_cnt == LAST_C);

    // R3: the bit clock is low in the cycle after a bit period ends.
    p_sck_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !sck_o);
    // R3: bit periods last more than one system clock.
    p_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> !bit_end);
endmodule

// File: rtl/sat_frame_ctr.sv
// Frame position counter and word-select decode. It advances once per bit
// period over 2*SLOT_W bits. frame_end marks the last system clock of the
// frame.
// Assumes: bit_end comes from sat_bitclk; fmt is held stable within a frame.
module sat_frame_ctr
    import sat_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bit_end,
    input  frame_fmt_e                       fmt,
    output logic [$clog2(2*SLOT_W)-1:0]      bit_cnt,
    output logic                             frame_end,
    output logic                             ws_o
);
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_C   = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0] SLOT_C   = BW'(SLOT_W);
    localparam logic [BW-1:0] EARLY_C  = BW'(SLOT_W - 1);

    // Bit position in the frame; reset to the last bit so a frame starts soon.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= LAST_C;
        end else if (bit_end) begin
            bit_cnt <= (bit_cnt == LAST_C) ? '0 : bit_cnt + 1'b1;
        end
    end

    assign frame_end = bit_end && (bit_cnt == LAST_C);

    // Word select: in I2S it leads the slot by one bit, in left-justified it aligns with it.
    always_comb begin
        if (fmt == FMT_MSB) ws_o = (bit_cnt >= SLOT_C);
        else                ws_o = (bit_cnt >= EARLY_C) && (bit_cnt != LAST_C);
    end

    // R3: word select moves only right after a bit period ends.
    p_ws_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_end) |-> $stable(ws_o));
    // R5: in left-justified framing, word select is low at frame start.
    p_ws_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == '0 && fmt == FMT_MSB) |-> !ws_o);
endmodule

// File: rtl/sat_shifter.sv
// Sample holding registers and serial data decode. A pair, or zeros on
// underrun or when disabled, is loaded at each frame boundary. The current
// bit is then picked by frame position, MSB first, with the slot tail zero.
// Assumes: SAMPLE_W <= SLOT_W.
module sat_shifter #(
    parameter int SAMPLE_W = 18,
    parameter int SLOT_W   = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frame_end,
    input  logic                           en_next,
    input  logic                           s_valid,
    input  logic [SAMPLE_W-1:0]            s_left,
    input  logic [SAMPLE_W-1:0]            s_right,
    input  logic [$clog2(2*SLOT_W)-1:0]    bit_cnt,
    output logic                           underrun_o,
    output logic                           sdo_o
);
    localparam int BW = $clog2(2 * SLOT_W);
    localparam logic [BW-1:0] SLOT_C = BW'(SLOT_W);
    localparam logic [BW-1:0] SAMP_C = BW'(SAMPLE_W);

    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    logic                take;
    logic                chan_r;
    logic [BW-1:0]       pos;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] shifted;

    assign take = en_next && s_valid;

    // Load the pair at the boundary, or silence when nothing valid is offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q     <= '0;
            right_q    <= '0;
            underrun_o <= 1'b0;
        end else begin
            underrun_o <= frame_end && en_next && !s_valid;
            if (frame_end) begin
                left_q  <= take ? s_left  : '0;
                right_q <= take ? s_right : '0;
            end
        end
    end

    // Select channel and slot position, then the bit at that position.
    always_comb begin
        chan_r  = (bit_cnt >= SLOT_C);
        pos     = chan_r ? (bit_cnt - SLOT_C) : bit_cnt;
        word    = chan_r ? right_q : left_q;
        shifted = word << pos;
        sdo_o   = (pos < SAMP_C) ? shifted[SAMPLE_W-1] : 1'b0;
    end

    // R4: positions beyond the significant bits carry zero.
    p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= SAMP_C) |-> !sdo_o);
    // R9: an underrun pulse follows a boundary and comes with silent samples.
    p_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> ($past(frame_end) && left_q == '0 && right_q == '0));
endmodule

// File: rtl/serial_audio_tx.sv
// Master serial audio transmitter. It derives the bit clock and word select
// from clk and shifts out 18-bit stereo pairs in 32-bit slots, in I2S or
// left-justified framing. The outputs stay tri-stated until enabled, and
// enable and format are applied only at frame boundaries.
// Assumes: the source holds s_left/s_right stable while s_valid is high.
module serial_audio_tx
    import sat_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int SLOT_W   = 32,
    parameter int CLK_DIV  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                fmt_msb,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                underrun,
    output logic                sck,
    output logic                ws,
    output logic                sdo
);
    localparam int BW = $clog2(2 * SLOT_W);

    logic          bit_end;
    logic          frame_end;
    logic          sck_i;
    logic          ws_i;
    logic          sdo_i;
    logic [BW-1:0] bit_cnt;
    logic          drive_q;
    frame_fmt_e    fmt_q;

    sat_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_end (bit_end),
        .sck_o   (sck_i)
    );

    sat_frame_ctr #(.SLOT_W(SLOT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_end   (bit_end),
        .fmt       (fmt_q),
        .bit_cnt   (bit_cnt),
        .frame_end (frame_end),
        .ws_o      (ws_i)
    );

    sat_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .en_next    (enable),
        .s_valid    (s_valid),
        .s_left     (s_left),
        .s_right    (s_right),
        .bit_cnt    (bit_cnt),
        .underrun_o (underrun),
        .sdo_o      (sdo_i)
    );

    // Drive and format state, changed only at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            fmt_q   <= FMT_I2S;
        end else if (frame_end) begin
            drive_q <= enable;
            fmt_q   <= frame_fmt_e'(fmt_msb);
        end
    end

    assign s_ready = frame_end && enable;

    // Tri-state output stage.
    assign sck = drive_q ? sck_i : 1'bz;
    assign ws  = drive_q ? ws_i  : 1'bz;
    assign sdo = drive_q ? sdo_i : 1'bz;

    // R2: the drive state changes only across a frame boundary.
    p_drive_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_q != $past(drive_q)) |-> $past(frame_end));
    // R7: the format changes only across a frame boundary.
    p_fmt_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q != $past(fmt_q)) |-> $past(frame_end));
    // R8: ready is a single-cycle pulse.
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);
    // R2: driving begins with the bit clock low at the start of a bit.
    p_drive_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_q) |-> (bit_cnt == '0 && !sck_i));
endmodule

// File: tb/serial_audio_tx_bench.sv
// Bench: a receiver-side model decodes the serial lines and checks every bit
// against expected values computed from the handshake and framing rules.
module serial_audio_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW  = 18;
    localparam int DIV = 4;
    localparam int HALF = DIV / 2;
    localparam int FRAME_CYC = 64 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic fmt_msb = 1'b0;
    logic s_valid = 1'b1;
    logic s_ready;
    logic [SW-1:0] s_left;
    logic [SW-1:0] s_right;
    logic underrun;
    logic sck;
    logic ws;
    logic sdo;

    int checks = 0;
    int failures = 0;
    int pat_idx = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_audio_tx #(.SAMPLE_W(SW), .SLOT_W(32), .CLK_DIV(DIV)) u_serial_audio_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fmt_msb(fmt_msb),
        .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .underrun(underrun), .sck(sck), .ws(ws), .sdo(sdo)
    );

    function automatic logic [SW-1:0] left_of(int i);
        case (i % 6)
            0: left_of = 18'h3FFFF;
            1: left_of = 18'h20000;
            2: left_of = 18'h2AAAA;
            default: left_of = SW'(i * 32'h2F3A5 + 32'h1234);
        endcase
    endfunction

    function automatic logic [SW-1:0] right_of(int i);
        case (i % 6)
            0: right_of = 18'h00000;
            1: right_of = 18'h00001;
            2: right_of = 18'h15555;
            default: right_of = SW'((i * 32'h1B6D3) ^ 32'h3C3C3);
        endcase
    endfunction

    assign s_left  = left_of(pat_idx);
    assign s_right = right_of(pat_idx);

    // Source: move to the next pattern after each accepted pair.
    always @(posedge clk) if (rst_n && s_ready && s_valid) pat_idx <= pat_idx + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Receiver-side model state.
    logic [SW-1:0] pend_l, pend_r, cur_l, cur_r;
    logic pend_fmt, cur_fmt, exp_und;
    bit   pend_ok = 0, prev_ready = 0, was_driven = 0;
    logic prev_sck = 0, prev_ws = 0, prev_sdo = 0;
    int   idx = 0, hi_run = 0, lo_run = 0;

    function automatic logic exp_ws(int b, logic f);
        if (f) return (b >= 32);
        return (b >= 31) && (b != 63);
    endfunction

    function automatic logic exp_sdo(int b, logic [SW-1:0] l, logic [SW-1:0] r);
        int p;
        logic [SW-1:0] w;
        p = b % 32;
        w = (b >= 32) ? r : l;
        if (p < SW) return w[SW-1-p];
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit driven;
            driven = (sck !== 1'bz);
            // R9: underrun appears only right after a boundary without valid data.
            if (prev_ready) chk(underrun === exp_und, "R9 underrun after boundary", int'(underrun), int'(exp_und));
            else            chk(underrun === 1'b0, "R9 underrun idle", int'(underrun), 0);
            if (!was_driven && driven) begin
                chk(prev_ready && pend_ok, "R2 drive starts at boundary", int'(prev_ready), 1);
                chk(sck === 1'b0, "R3 sck low at bit 0", int'(sck), 0);
                cur_l = pend_l; cur_r = pend_r; cur_fmt = pend_fmt; pend_ok = 0;
                idx = 0; lo_run = 1; hi_run = 0;
            end else if (was_driven && !driven) begin
                chk(idx == 63 && prev_sck === 1'b1, "R2 release after bit 63", idx, 63);
                chk(ws === 1'bz && sdo === 1'bz, "R1 all lines released", int'(ws), 0);
            end else if (driven) begin
                if (prev_sck === 1'b0 && sck === 1'b1) begin
                    chk(lo_run == HALF, "R3 low half length", lo_run, HALF);
                    hi_run = 1;
                    chk(ws === exp_ws(idx, cur_fmt), cur_fmt ? "R5 ws msb framing" : "R6 ws i2s framing",
                        int'(ws), int'(exp_ws(idx, cur_fmt)));
                    chk(sdo === exp_sdo(idx, cur_l, cur_r), "R4 data bit", int'(sdo),
                        int'(exp_sdo(idx, cur_l, cur_r)));
                end else if (prev_sck === 1'b1 && sck === 1'b0) begin
                    chk(hi_run == HALF, "R3 high half length", hi_run, HALF);
                    lo_run = 1;
                    if (idx == 63) begin
                        chk(prev_ready && pend_ok, "R8 ready at frame end", int'(prev_ready), 1);
                        cur_l = pend_l; cur_r = pend_r; cur_fmt = pend_fmt; pend_ok = 0;
                        idx = 0;
                    end else begin
                        idx++;
                    end
                end else begin
                    if (sck === 1'b1) hi_run++; else lo_run++;
                    chk(ws === prev_ws && sdo === prev_sdo, "R3 lines hold within bit", int'(ws), int'(prev_ws));
                end
            end else begin
                chk(ws === 1'bz && sdo === 1'bz, "R1 lines high-Z while disabled", int'(ws), 0);
            end
            prev_ready = 0;
            if (s_ready) begin
                chk(enable === 1'b1, "R8 ready only when enabled", int'(enable), 1);
                pend_l = s_valid ? s_left : '0;
                pend_r = s_valid ? s_right : '0;
                pend_fmt = fmt_msb;
                exp_und = !s_valid;
                pend_ok = 1;
                prev_ready = 1;
            end
            was_driven = driven;
            prev_sck = sck; prev_ws = ws; prev_sdo = sdo;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(sck === 1'bz && ws === 1'bz && sdo === 1'bz, "R1 high-Z in reset", int'(sck), 0);
        chk(s_ready === 1'b0 && underrun === 1'b0, "R10 handshake cleared in reset", int'(s_ready), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (300) @(posedge clk);
        #1 enable = 1'b1;                    // mid-frame: applied at next boundary (R2)
        repeat (FRAME_CYC * 4) @(posedge clk);
        #1 fmt_msb = 1'b1;                   // mid-frame format change (R7)
        repeat (FRAME_CYC * 3) @(posedge clk);
        #1 s_valid = 1'b0;                   // exactly one boundary without data (R9)
        repeat (FRAME_CYC) @(posedge clk);
        #1 s_valid = 1'b1;
        repeat (FRAME_CYC * 2) @(posedge clk);
        #1 enable = 1'b0;                    // mid-frame disable (R2)
        repeat (FRAME_CYC * 2) @(posedge clk);
        #1 begin enable = 1'b1; fmt_msb = 1'b0; end
        repeat (FRAME_CYC * 3) @(posedge clk);
        #1 enable = 1'b0;
        repeat (FRAME_CYC + 40) @(posedge clk);
        chk(pat_idx >= 10, "R8 pairs consumed", pat_idx, 10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R8 watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule